// File: doc/BRIEF.md
# DMA Channel Trigger Latch with Overflow Detection

This block sits in front of one DMA channel and decides when the transfer engine should start a burst. A select field picks one line out of a vector of peripheral event pulses. A software strobe can force a trigger whatever the select field holds. The chosen event is held in a single pending flag, and that flag is the burst request seen by the engine. The flag stays set until the engine acknowledges by starting the burst.

A channel holds only one pending event. If another trigger arrives while one is still waiting, the block records an overflow in a sticky status bit, and software clears that bit with a write-one-to-clear strobe. When the overflow interrupt is enabled, the status bit is merged with the channel's normal completion interrupt onto one interrupt output.

The pending logic is a two-state machine. In `TL_IDLE` nothing is waiting. In `TL_PEND` the burst request is raised. The transitions are: `TL_IDLE -> TL_PEND` on a trigger, `TL_PEND -> TL_IDLE` on an acknowledge without a new trigger, and `TL_PEND -> TL_PEND` on any other input, which covers hold, re-trigger with acknowledge, and overflow. Reset enters `TL_IDLE`.

Top module: `dma_trig_latch`

## Requirements
- R1: Select codes 0, 6, 16 and 17 are empty codes. While one of them is selected, no level on any source line causes a burst request.
- R2: For any other select code k, a high on source line k in a cycle raises `burst_req_o` from the next cycle on. High levels on the lines that are not selected have no effect.
- R3: A one-cycle pulse on `force_i` raises `burst_req_o` in the next cycle for every select code, including the empty ones.
- R4: Once raised, `burst_req_o` stays high until a cycle with `burst_ack_i` high. It is low in the cycle after that acknowledge, unless a trigger came in that same cycle. An acknowledge while nothing is pending has no effect.
- R5: When a trigger and an acknowledge arrive in the same cycle, `burst_req_o` stays high and no overflow is recorded.
- R6: A trigger in a cycle where the request is already pending and no acknowledge is given sets `ovf_flag_o` in the next cycle. `burst_req_o` stays high.
- R7: `ovf_flag_o` is sticky. It clears only in the cycle after `ovf_clr_i` is high. If a new overflow is detected in the same cycle as the clear, the set wins and the flag stays high.
- R8: `chan_irq_o` is combinational and equals `chan_int_i OR (ovf_flag_o AND ovf_ie_i)`. With `ovf_ie_i` low, an overflow never reaches the interrupt.
- R9: Reset (asynchronous, `rst_n` low) clears both the pending request and the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Peripheral event pulses, one per line |
| sel_i | input | 5 | Trigger source select code |
| force_i | input | 1 | Software trigger strobe |
| ovf_ie_i | input | 1 | Overflow interrupt enable |
| burst_ack_i | input | 1 | Engine has started the burst |
| ovf_clr_i | input | 1 | Write-one-to-clear strobe for the overflow flag |
| chan_int_i | input | 1 | Normal channel completion interrupt |
| burst_req_o | output | 1 | Burst request, equal to the pending flag |
| chan_irq_o | output | 1 | Combined channel interrupt |
| ovf_flag_o | output | 1 | Sticky overflow status |

## Verification
The hardest cases to reach are the ones where two things happen in the same cycle on a channel that is already pending. The first is a trigger landing together with the acknowledge, which must not count as an overflow. The second is an overflow detected in the very cycle software clears the flag. Directed steps first bring the channel into the pending state and then apply each collision. Seeded random traffic with dense source pulses and frequent acknowledges reaches the same situations many more times, and a bench model follows it cycle by cycle.

// File: rtl/dma_trig_pkg.sv
package dma_trig_pkg;

    typedef enum logic {
        TL_IDLE = 1'b0,
        TL_PEND = 1'b1
    } tl_state_t;

endpackage

// File: rtl/dma_trig_srcsel.sv
module dma_trig_srcsel #(
    parameter int                  NUM_SRC   = 32,
    parameter int                  SEL_W     = $clog2(NUM_SRC),
    parameter logic [NUM_SRC-1:0]  EMPTY_MAP = 32'h0003_0041
) (
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic               force_i,
    output logic               trig_o
);

    logic [NUM_SRC-1:0] live;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_gate
        if (EMPTY_MAP[g]) begin : g_empty
            assign live[g] = 1'b0;
        end else begin : g_pass
            assign live[g] = src_i[g];
        end
    end

    assign trig_o = live[sel_i] | force_i;

endmodule

// File: rtl/dma_trig_fsm.sv
module dma_trig_fsm
    import dma_trig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic ack_i,
    output logic pend_o,
    output logic ovf_det_o
);

    tl_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TL_IDLE: if (trig_i) state_d = TL_PEND;
            TL_PEND: if (ack_i && !trig_i) state_d = TL_IDLE;
            default: state_d = TL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pend_o    = 1'b0;
        ovf_det_o = 1'b0;
        unique case (state_q)
            TL_IDLE: ;
            TL_PEND: begin
                pend_o    = 1'b1;
                ovf_det_o = trig_i && !ack_i;
            end
            default: ;
        endcase
    end

    AST_TRIG_RAISES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        trig_i |=> pend_o); // R2
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !ack_i) |=> pend_o); // R4
    AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && ack_i && !trig_i) |=> !pend_o); // R4
    AST_ACK_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && trig_i) |-> !ovf_det_o); // R5

endmodule

// File: rtl/dma_trig_ovf.sv
module dma_trig_ovf (
    input  logic clk,
    input  logic rst_n,
    input  logic det_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (det_i) flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        det_i |=> flag_o); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o); // R7
    AST_OVF_NO_SELF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && !det_i) |=> !flag_o); // R6

endmodule

// File: rtl/dma_trig_latch.sv
module dma_trig_latch #(
    parameter int                  NUM_SRC   = 32,
    parameter int                  SEL_W     = $clog2(NUM_SRC),
    parameter logic [NUM_SRC-1:0]  EMPTY_MAP = 32'h0003_0041
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic               force_i,
    input  logic               ovf_ie_i,
    input  logic               burst_ack_i,
    input  logic               ovf_clr_i,
    input  logic               chan_int_i,
    output logic               burst_req_o,
    output logic               chan_irq_o,
    output logic               ovf_flag_o
);

    logic trig;
    logic ovf_det;

    dma_trig_srcsel #(
        .NUM_SRC   (NUM_SRC),
        .SEL_W     (SEL_W),
        .EMPTY_MAP (EMPTY_MAP)
    ) u_srcsel (
        .src_i   (src_i),
        .sel_i   (sel_i),
        .force_i (force_i),
        .trig_o  (trig)
    );

    dma_trig_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_i    (trig),
        .ack_i     (burst_ack_i),
        .pend_o    (burst_req_o),
        .ovf_det_o (ovf_det)
    );

    dma_trig_ovf u_ovf (
        .clk    (clk),
        .rst_n  (rst_n),
        .det_i  (ovf_det),
        .clr_i  (ovf_clr_i),
        .flag_o (ovf_flag_o)
    );

    assign chan_irq_o = chan_int_i | (ovf_flag_o & ovf_ie_i);

    AST_EMPTY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_req_o && EMPTY_MAP[sel_i] && !force_i) |=> !burst_req_o); // R1
    AST_FORCE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        force_i |=> burst_req_o); // R3
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_ie_i && !chan_int_i) |-> !chan_irq_o); // R8
    AST_IRQ_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        chan_int_i |-> chan_irq_o); // R8

endmodule

// File: tb/tb_dma_trig_latch.sv
module tb_dma_trig_latch;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic [4:0]  sel = '0;
    logic        frc = 1'b0, ie = 1'b0, ack = 1'b0, clr = 1'b0, ci = 1'b0;
    logic        burst_req, chan_irq, ovf_flag;

    int total = 0;
    int bad   = 0;
    logic m_pend = 1'b0;
    logic m_ovf  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_trig_latch dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src),
        .sel_i       (sel),
        .force_i     (frc),
        .ovf_ie_i    (ie),
        .burst_ack_i (ack),
        .ovf_clr_i   (clr),
        .chan_int_i  (ci),
        .burst_req_o (burst_req),
        .chan_irq_o  (chan_irq),
        .ovf_flag_o  (ovf_flag)
    );

    function automatic logic is_empty(input logic [4:0] s);
        return (s == 5'd0) || (s == 5'd6) || (s == 5'd16) || (s == 5'd17);
    endfunction

    function automatic logic trig_of(input logic [31:0] v, input logic [4:0] s, input logic f);
        return f | (!is_empty(s) & v[s]);
    endfunction

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Called at a negedge: drive, check comb irq, advance model, check registered outputs.
    task automatic step(input logic [31:0] v, input logic [4:0] s, input logic f,
                        input logic e, input logic a, input logic c, input logic i,
                        input string tag);
        logic t, det, np, no;
        src = v; sel = s; frc = f; ie = e; ack = a; clr = c; ci = i;
        #1;
        chk("R8", "chan_irq_o", chan_irq, i | (m_ovf & e));
        t   = trig_of(v, s, f);
        det = m_pend & t & !a;
        np  = t | (m_pend & !a);
        no  = det | (m_ovf & !c);
        @(negedge clk);
        m_pend = np;
        m_ovf  = no;
        chk(tag, "burst_req_o", burst_req, m_pend);
        chk(tag, "ovf_flag_o", ovf_flag, m_ovf);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        src = '0; sel = '0; frc = 0; ie = 0; ack = 0; clr = 0; ci = 0;
        @(negedge clk);
        @(negedge clk);
        m_pend = 1'b0;
        m_ovf  = 1'b0;
        chk("R9", "burst_req_o in reset", burst_req, 1'b0);
        chk("R9", "ovf_flag_o in reset", ovf_flag, 1'b0);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // R1: empty codes ignore every source line
        step(32'hFFFF_FFFF, 5'd0,  0, 0, 0, 0, 0, "R1");
        step(32'hFFFF_FFFF, 5'd6,  0, 0, 0, 0, 0, "R1");
        step(32'hFFFF_FFFF, 5'd16, 0, 0, 0, 0, 0, "R1");
        step(32'hFFFF_FFFF, 5'd17, 0, 0, 0, 0, 0, "R1");
        // R2: unselected lines ignored, selected line triggers
        step(32'hFFFF_FFF7, 5'd3,  0, 0, 0, 0, 0, "R2");
        step(32'h0000_0008, 5'd3,  0, 0, 0, 0, 0, "R2");
        // R4: holds without ack, drops after ack
        step(32'h0, 5'd3, 0, 0, 0, 0, 0, "R4");
        step(32'h0, 5'd3, 0, 0, 1, 0, 0, "R4");
        step(32'h0, 5'd3, 0, 0, 1, 0, 0, "R4");   // ack while idle
        // R3: force with an empty code
        step(32'h0, 5'd0, 1, 0, 0, 0, 0, "R3");
        // R5: trigger together with ack
        step(32'h8000_0000, 5'd31, 0, 1, 1, 0, 0, "R5");
        // R6: trigger while pending
        step(32'h8000_0000, 5'd31, 0, 1, 0, 0, 0, "R6");
        // R8: enabled overflow reaches the interrupt, disabled does not
        step(32'h0, 5'd31, 0, 1, 0, 0, 0, "R8");
        step(32'h0, 5'd31, 0, 0, 0, 0, 0, "R8");
        step(32'h0, 5'd31, 0, 0, 0, 0, 1, "R8");
        // R7: sticky, then clear collides with new overflow, then plain clear
        step(32'h0, 5'd31, 0, 0, 1, 0, 0, "R7");
        step(32'h0, 5'd31, 1, 0, 0, 0, 0, "R7");
        step(32'h0, 5'd31, 1, 0, 0, 1, 0, "R7");
        step(32'h0, 5'd31, 0, 0, 0, 1, 0, "R7");
        // R9: reset mid-run with pending request
        step(32'h0, 5'd31, 1, 0, 0, 0, 0, "R9");
        do_reset();

        // seeded random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] v;
            logic [4:0]  s;
            v = $urandom() & $urandom();
            s = 5'($urandom_range(0, 31));
            step(v, s, ($urandom_range(0, 9) == 0), 1'($urandom()),
                 ($urandom_range(0, 2) == 0), ($urandom_range(0, 5) == 0),
                 ($urandom_range(0, 7) == 0), "R6");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule